// File: doc/BRIEF.md
# Next-Interrupt Priority Selector

This block decides which interrupt source a processor core should take next. Each cycle it reads a vector of sixteen pending request bits. It also reads the core's machine-state bits: external enable, critical enable, hypervisor mode and problem (user) state. It reads a resume-as-soft-reset flag and the partition-control enable bits, plus a global enable for event-based branches.

Every source is first qualified by its own enable term. A fixed-priority search then picks the highest-ranked qualified request, and the result is registered. The output is a valid flag and an encoded identifier. The core uses them to vector the interrupt. Delivery, acknowledgment and clearing of pending bits stay in the core.

The result is a per-cycle status that is recomputed from scratch every cycle. It is not a stream item, so there is no valid/ready pair. The consumer cannot apply back-pressure, and it simply reads the registered choice on the cycle it needs it.

Top module: `intr_next_sel`

## Requirements
- R1: Pending bit 0 (system reset) always wins and yields identifier 1, whatever the enable and state inputs are.
- R2: Pending bit 1 (machine check) yields identifier 2 whenever bit 0 is clear, with no enable needed.
- R3: Pending bit 2 (hypervisor decrementer) qualifies only when `pc_hdec_en` is 1 and either asynchronous delivery is allowed or `st_hyp` is 0. Asynchronous delivery is allowed when `st_ext_en` OR `resume_soft_rst` is 1. It yields identifier 3.
- R4: Pending bit 3 (hypervisor virtualization) qualifies the same way as R3, using `pc_hvirt_en` in place of `pc_hdec_en`. It yields identifier 4 and ranks directly below bit 2.
- R5: Pending bit 4 (external) qualifies in either of two cases, and yields identifier 5. The first case is that asynchronous delivery is allowed and it is not true that `pc_hyp_ext_block`=1, `st_hyp`=1 and `st_user`=0 all hold. The second case is that the core is hypervisor-capable (parameter default), `st_hyp`=0 and `pc_ext_route`=0.
- R6: Pending bit 5 (critical external) qualifies only when `st_crit_en` is 1. It yields identifier 6 and ranks below bit 4.
- R7: Pending bits 6 to 14 qualify only while asynchronous delivery is allowed. They rank in the order of their bit index, lower index winning. The sources are watchdog, critical doorbell, fixed-interval timer, programmable-interval timer, decrementer, doorbell, hypervisor doorbell, performance monitor and thermal. Bit i yields identifier i+1.
- R8: Pending bit 15 (event-based branch) qualifies only when asynchronous delivery is allowed, `st_user` is 1 and `ebb_glob_en` is 1. It yields identifier 16.
- R9: When no qualified source is pending, `take_valid` is 0 and `take_id` is 0. Otherwise `take_valid` is 1 and `take_id` is the winner's bit index plus 1.
- R10: The outputs reflect the inputs seen at the previous rising clock edge. A synchronous reset (`rst`=1) at an edge forces `take_valid` and `take_id` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 16 | Pending request bits, bit index = priority rank |
| st_ext_en | input | 1 | Machine state: external interrupts enabled |
| st_crit_en | input | 1 | Machine state: critical interrupts enabled |
| st_hyp | input | 1 | Machine state: hypervisor mode |
| st_user | input | 1 | Machine state: problem (user) state |
| resume_soft_rst | input | 1 | Wake-up will resume as a soft reset |
| pc_hdec_en | input | 1 | Partition control: hypervisor decrementer enable |
| pc_hvirt_en | input | 1 | Partition control: hypervisor virtualization enable |
| pc_ext_route | input | 1 | Partition control: route external interrupt to hypervisor |
| pc_hyp_ext_block | input | 1 | Partition control: block external delivery in hypervisor |
| ebb_glob_en | input | 1 | Event-based branch global enable |
| take_valid | output | 1 | A qualified source was selected |
| take_id | output | 5 | Identifier of the selected source, 0 when none |

## Verification
Every result is due exactly one rising edge after its inputs are applied, and reset takes effect with the same one-edge delay. The driver changes inputs on the falling edge and queues the expected valid and identifier it derives from the requirements. The monitor pops one expectation one time unit after each rising edge, so each comparison lands on the first cycle in which the registered choice for those inputs is visible. Directed cases walk each qualifier through its enabling and disabling combinations and peel the asynchronous tier one source at a time. A randomized run follows.

// File: rtl/isel_pkg.sv
package isel_pkg;

  localparam int ISEL_NSRC = 16;

  // Source ranks; rank equals pending bit index, lower rank wins.
  localparam int SRC_SRESET = 0;
  localparam int SRC_MCHK   = 1;
  localparam int SRC_HDEC   = 2;
  localparam int SRC_HVIRT  = 3;
  localparam int SRC_EXT    = 4;
  localparam int SRC_CEXT   = 5;
  localparam int SRC_WDOG   = 6;
  localparam int SRC_THERM  = 14;
  localparam int SRC_EBB    = 15;

  // First and last rank of the tier gated only by asynchronous delivery.
  localparam int ASYNC_LO = SRC_WDOG;
  localparam int ASYNC_HI = SRC_THERM;

  typedef struct packed {
    logic ext_en;
    logic crit_en;
    logic hyp;
    logic user;
    logic resume_sreset;
    logic hdec_en;
    logic hvirt_en;
    logic ext_route;
    logic hyp_ext_block;
    logic ebb_ge;
  } isel_ctx_t;

endpackage

// File: rtl/isel_qualify.sv
module isel_qualify
  import isel_pkg::*;
#(
  parameter int  NSRC        = ISEL_NSRC,
  parameter bit  HYP_CAPABLE = 1'b1
) (
  input  logic [NSRC-1:0] pend,
  input  isel_ctx_t       ctx,
  output logic [NSRC-1:0] qual
);

  logic            async_ok;
  logic [NSRC-1:0] fixed_q;
  logic [NSRC-1:0] tier_q;

  assign async_ok = ctx.ext_en | ctx.resume_sreset;

  // Sources with individual gating terms.
  always_comb begin
    fixed_q = '0;
    fixed_q[SRC_SRESET] = pend[SRC_SRESET];
    fixed_q[SRC_MCHK]   = pend[SRC_MCHK];
    fixed_q[SRC_HDEC]   = pend[SRC_HDEC] & ctx.hdec_en & (async_ok | ~ctx.hyp);
    fixed_q[SRC_HVIRT]  = pend[SRC_HVIRT] & ctx.hvirt_en & (async_ok | ~ctx.hyp);
    fixed_q[SRC_EXT]    = pend[SRC_EXT] &
                          ((async_ok & ~(ctx.hyp_ext_block & ctx.hyp & ~ctx.user)) |
                           (HYP_CAPABLE & ~ctx.hyp & ~ctx.ext_route));
    fixed_q[SRC_CEXT]   = pend[SRC_CEXT] & ctx.crit_en;
    fixed_q[SRC_EBB]    = pend[SRC_EBB] & async_ok & ctx.user & ctx.ebb_ge;
  end

  // Uniform tier: each source gated by asynchronous delivery alone.
  for (genvar i = 0; i < NSRC; i++) begin : g_tier
    if (i >= ASYNC_LO && i <= ASYNC_HI) begin : g_on
      assign tier_q[i] = pend[i] & async_ok;
    end else begin : g_off
      assign tier_q[i] = 1'b0;
    end
  end

  assign qual = fixed_q | tier_q;

endmodule

// File: rtl/isel_pick.sv
module isel_pick #(
  parameter int NSRC = 16,
  localparam int ID_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0] req,
  output logic            hit,
  output logic [ID_W-1:0] id
);

  logic [NSRC-1:0] grant;

  // Lowest index wins.
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < NSRC; i++) begin
      grant[i] = req[i] & ~seen;
      seen     = seen | req[i];
    end
  end

  // Identifier is rank plus one; zero is reserved for none.
  always_comb begin
    id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) id = id | ID_W'(i + 1);
    end
  end

  assign hit = |req;

endmodule

// File: rtl/isel_hold.sv
module isel_hold #(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit_d,
  input  logic [ID_W-1:0] id_d,
  output logic            hit_q,
  output logic [ID_W-1:0] id_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      id_q  <= '0;
    end else begin
      hit_q <= hit_d;
      id_q  <= id_d;
    end
  end

endmodule

// File: rtl/intr_next_sel.sv
module intr_next_sel
  import isel_pkg::*;
#(
  parameter bit  HYP_CAPABLE = 1'b1,
  localparam int NSRC = ISEL_NSRC,
  localparam int ID_W = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_i,
  input  logic            st_ext_en,
  input  logic            st_crit_en,
  input  logic            st_hyp,
  input  logic            st_user,
  input  logic            resume_soft_rst,
  input  logic            pc_hdec_en,
  input  logic            pc_hvirt_en,
  input  logic            pc_ext_route,
  input  logic            pc_hyp_ext_block,
  input  logic            ebb_glob_en,
  output logic            take_valid,
  output logic [ID_W-1:0] take_id
);

  isel_ctx_t       ctx;
  logic [NSRC-1:0] qual;
  logic            hit;
  logic [ID_W-1:0] id;

  always_comb begin
    ctx.ext_en        = st_ext_en;
    ctx.crit_en       = st_crit_en;
    ctx.hyp           = st_hyp;
    ctx.user          = st_user;
    ctx.resume_sreset = resume_soft_rst;
    ctx.hdec_en       = pc_hdec_en;
    ctx.hvirt_en      = pc_hvirt_en;
    ctx.ext_route     = pc_ext_route;
    ctx.hyp_ext_block = pc_hyp_ext_block;
    ctx.ebb_ge        = ebb_glob_en;
  end

  isel_qualify #(.NSRC(NSRC), .HYP_CAPABLE(HYP_CAPABLE)) u_qual (
    .pend (pend_i),
    .ctx  (ctx),
    .qual (qual)
  );

  isel_pick #(.NSRC(NSRC)) u_pick (
    .req (qual),
    .hit (hit),
    .id  (id)
  );

  isel_hold #(.ID_W(ID_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .hit_d (hit),
    .id_d  (id),
    .hit_q (take_valid),
    .id_q  (take_id)
  );

endmodule

// File: rtl/isel_chk.sv
module isel_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] pend_i,
  input logic        st_ext_en,
  input logic        st_crit_en,
  input logic        st_user,
  input logic        resume_soft_rst,
  input logic        pc_hdec_en,
  input logic        ebb_glob_en,
  input logic        take_valid,
  input logic [4:0]  take_id
);

  // R1
  sreset_first_chk: assert property (@(posedge clk) disable iff (rst)
    pend_i[0] |=> (take_valid && take_id == 5'd1));

  // R2
  mchk_second_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_i[0] && pend_i[1]) |=> (take_valid && take_id == 5'd2));

  // R3
  hdec_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i == 16'h0004 && !pc_hdec_en) |=> !take_valid);

  // R6
  cext_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i == 16'h0020 && !st_crit_en) |=> !take_valid);

  // R7
  async_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & 16'h003f) == 16'h0000 && pend_i != 16'h0000 &&
     !st_ext_en && !resume_soft_rst) |=> !take_valid);

  // R8
  ebb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i == 16'h8000 && !(st_user && ebb_glob_en)) |=> !take_valid);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i == 16'h0000) |=> (!take_valid && take_id == 5'd0));

  // R9
  valid_id_chk: assert property (@(posedge clk) disable iff (rst)
    take_valid == (take_id != 5'd0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!take_valid && take_id == 5'd0));

endmodule

bind intr_next_sel isel_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .pend_i          (pend_i),
  .st_ext_en       (st_ext_en),
  .st_crit_en      (st_crit_en),
  .st_user         (st_user),
  .resume_soft_rst (resume_soft_rst),
  .pc_hdec_en      (pc_hdec_en),
  .ebb_glob_en     (ebb_glob_en),
  .take_valid      (take_valid),
  .take_id         (take_id)
);

// File: tb/intr_next_sel_tb.sv
module intr_next_sel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic       v;
    logic [4:0] id;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] pend;
  logic        ee, ce, hv, pr, rs, hde, hve, lpes, heic, ge;
  logic        take_valid;
  logic [4:0]  take_id;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_next_sel u_dut (
    .clk              (clk),
    .rst              (rst),
    .pend_i           (pend),
    .st_ext_en        (ee),
    .st_crit_en       (ce),
    .st_hyp           (hv),
    .st_user          (pr),
    .resume_soft_rst  (rs),
    .pc_hdec_en       (hde),
    .pc_hvirt_en      (hve),
    .pc_ext_route     (lpes),
    .pc_hyp_ext_block (heic),
    .ebb_glob_en      (ge),
    .take_valid       (take_valid),
    .take_id          (take_id)
  );

  // Expected identifier from the requirement text; 0 means none.
  function automatic logic [4:0] model();
    logic a;
    a = ee | rs;
    if (pend[0]) return 5'd1;
    if (pend[1]) return 5'd2;
    if (pend[2] && hde && (a || !hv)) return 5'd3;
    if (pend[3] && hve && (a || !hv)) return 5'd4;
    if (pend[4] && ((a && !(heic && hv && !pr)) || (!hv && !lpes))) return 5'd5;
    if (pend[5] && ce) return 5'd6;
    if (a) begin
      for (int i = 6; i <= 14; i++) if (pend[i]) return 5'(i + 1);
      if (pend[15] && pr && ge) return 5'd16;
    end
    return 5'd0;
  endfunction

  task automatic clear_ctl();
    pend = '0; ee = 0; ce = 0; hv = 0; pr = 0; rs = 0;
    hde = 0; hve = 0; lpes = 1; heic = 0; ge = 0;
  endtask

  // Driver: queue expectation for the inputs now applied, wait one cycle.
  task automatic go(string tag);
    exp_t e;
    e.id  = rst ? 5'd0 : model();
    e.v   = (e.id != 5'd0);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: result due one rising edge after the inputs.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (take_valid !== e.v || take_id !== e.id) begin
          errors++;
          $display("FAIL %s got valid=%0b id=%0d exp valid=%0b id=%0d",
                   e.tag, take_valid, take_id, e.v, e.id);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_ctl();
    rst = 1;
    pend = 16'hffff; ee = 1; ce = 1;
    go("R10");                      // reset clears despite requests
    go("R10");
    rst = 0;
    go("R1");                       // everything pending: reset wins
    clear_ctl(); pend = 16'h0001;
    go("R1");                       // no enables needed
    pend = 16'hfffe;
    go("R2");                       // machine check over the rest, no enables
    pend = 16'h0000;
    go("R9");

    // R3 hypervisor decrementer
    clear_ctl(); pend = 16'h0004; hv = 0;
    go("R3");                       // enable off: none
    hde = 1; hv = 1;
    go("R3");                       // hyp, no async: none
    hv = 0;
    go("R3");                       // non-hyp: taken
    hv = 1; rs = 1;
    go("R3");                       // resume flag allows async: taken
    rs = 0; ee = 1;
    go("R3");

    // R4 hypervisor virtualization
    clear_ctl(); pend = 16'h000c; hde = 1; hve = 1;
    go("R4");                       // decrementer ranks above
    hde = 0;
    go("R4");
    hv = 1;
    go("R4");                       // hyp, no async: none

    // R5 external
    clear_ctl(); pend = 16'h0010; ee = 1; heic = 1; hv = 1; pr = 0;
    go("R5");                       // blocked in hypervisor
    pr = 1;
    go("R5");                       // user state lifts the block
    ee = 0; pr = 0; hv = 0; lpes = 0;
    go("R5");                       // second path without async
    lpes = 1;
    go("R5");                       // route bit set: none
    heic = 0; hv = 1; ee = 1;
    go("R5");

    // R6 critical external
    clear_ctl(); pend = 16'h0020;
    go("R6");
    ce = 1;
    go("R6");
    pend = 16'h0030; ee = 1;
    go("R6");                       // external ranks above

    // R7 async tier order
    clear_ctl(); ee = 1; pend = 16'h7fc0;
    for (int i = 6; i <= 14; i++) begin
      go("R7");
      pend[i] = 1'b0;
    end
    pend = 16'h7fc0; ee = 0;
    go("R7");                       // async off: none
    rs = 1;
    go("R7");

    // R8 event-based branch
    clear_ctl(); pend = 16'h8000; ee = 1; ge = 1; pr = 0;
    go("R8");
    pr = 1; ge = 0;
    go("R8");
    ge = 1;
    go("R8");
    ee = 0;
    go("R8");

    clear_ctl();
    go("R9");

    // mid-run reset
    pend = 16'h0002; rst = 1;
    go("R10");
    rst = 0;
    go("R10");

    for (int n = 0; n < 400; n++) begin
      pend = 16'($urandom);
      if (n % 2 == 0) pend[1:0] = 2'b00;
      {ee, ce, hv, pr, rs, hde, hve, lpes, heic, ge} = 10'($urandom);
      go("MIX");
    end

    clear_ctl();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule